// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block sits beside a clock recovery loop and decides whether the loop should track the incoming serial data or fall back to a local reference clock. It divides the recovered clock, counts the divided edges, and measures the count over a fixed window of reference clock cycles. The measured count is compared with the count expected for the selected line rate. Lock is granted only when the error is small, and it is withdrawn only when the error grows much larger. Between those two limits the current decision is held.

Two level inputs override the frequency decision. One reports that the optical receiver sees a signal. The other asks for the loop to stay on the reference. If either override is active, lock drops on the next reference edge and the data output is forced low. Otherwise the data output passes the input data, retimed once on the recovered clock. The loop select output tells the analog loop which source to follow. The level inputs and the rate select are taken as synchronous to the reference clock.

Top module: `freq_lock_det`

## Requirements
- R1: While `rst` is high, `locked_o` and `follow_data_o` are 0 at every reference edge, and `tx_data_o` is 0 once reset has reached the recovered clock domain.
- R2: The frequency compare runs only at the end of each window of `WIN_CYCLES` reference cycles, counted from the first edge after reset is released. The first window end after reset only records a baseline count and never sets lock.
- R3: At a window end with no override active, an unlocked detector locks when |measured − expected| ≤ expected / 2^`ACQ_SHIFT` (about 250 ppm).
- R4: In the band between the two limits, the state is held: a locked detector stays locked while |error| ≤ expected / 2^`LOSS_SHIFT`, and an unlocked detector stays unlocked while |error| > expected / 2^`ACQ_SHIFT`.
- R5: At a window end, a locked detector unlocks when |error| > expected / 2^`LOSS_SHIFT` (about 1000 ppm).
- R6: While `sig_det_i` is 0, `locked_o` is 0 from the next reference edge on, and no window end can grant lock.
- R7: While `lock_ref_n_i` is 0, `locked_o` is 0 from the next reference edge on, and no window end can grant lock.
- R8: While either override is active, `tx_data_o` is 0. When neither is active, `tx_data_o` equals `rx_data_i` as sampled at the previous rising edge of `rec_clk`. The override reaches the recovered domain through a two-stage synchronizer.
- R9: The measured count is the number of rising `rec_clk` edges divided by 2^`DIV_LOG2`. The expected count is `WIN_CYCLES` when `rate_hi_i` = 0 and `WIN_CYCLES`·2^`RATE_SHIFT` when `rate_hi_i` = 1. Both limits scale with the expected count.
- R10: `follow_data_o` always equals `locked_o`. A value of 1 steers the loop to the data and 0 steers it to the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, which also times the measurement window |
| rst | input | 1 | Synchronous active-high reset, in the reference domain |
| rec_clk | input | 1 | Recovered clock from the loop |
| rate_hi_i | input | 1 | Line rate select: 1 is the high rate, 0 is the low rate (one quarter of the high rate) |
| sig_det_i | input | 1 | Receiver signal present, active high |
| lock_ref_n_i | input | 1 | Force the loop to the reference, active low |
| rx_data_i | input | 1 | Serial data in the recovered clock domain |
| locked_o | output | 1 | Frequency lock indication |
| follow_data_o | output | 1 | Loop select: 1 follows the data, 0 follows the reference |
| tx_data_o | output | 1 | Gated, retimed serial data |

## Verification
The bench steps the recovered clock through offsets of 0, ±200, ±600 and ±1500 ppm. It walks lock into the hysteresis band from both sides, so a detector with a single threshold would either lose lock at 600 ppm or regain it there. Each override is dropped in the middle of a window, which catches a design that waits for the window end to drop lock or that grants lock while an override is active. The rate select is changed and the low rate is then tested on its own, which exposes an expected count that does not follow the rate. The data output is compared on every recovered cycle, which shows a gate that leaks data or an output that does not pass the input.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic {
    LS_REF  = 1'b0,
    LS_DATA = 1'b1
  } loop_sel_e;

  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/fld_sync_bit.sv
// Multi-stage single-bit synchronizer into the clk domain.
module fld_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q[0] <= d_i;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fld_rec_counter.sv
// Recovered-domain prescaler and divided-edge counter, published in Gray code.
module fld_rec_counter #(
  parameter int CNT_W    = 18,
  parameter int DIV_LOG2 = 1
) (
  input  logic             rec_clk,
  input  logic             rec_rst,
  output logic [CNT_W-1:0] gray_o
);
  localparam int RAW_W = CNT_W + DIV_LOG2;

  logic [RAW_W-1:0] raw_q, raw_d;
  logic [CNT_W-1:0] div_d, gray_q;

  assign raw_d = raw_q + 1'b1;
  assign div_d = raw_d[RAW_W-1:DIV_LOG2];

  always_ff @(posedge rec_clk) begin
    if (rec_rst) begin
      raw_q  <= '0;
      gray_q <= '0;
    end else begin
      raw_q  <= raw_d;
      gray_q <= div_d ^ (div_d >> 1);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/fld_gray_sync.sv
// Brings a Gray-coded count into the clk domain and converts it to binary.
module fld_gray_sync #(
  parameter int W      = 18,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] bin_c;
  logic         acc;

  always_ff @(posedge clk) begin
    stage_q[0] <= gray_i;
    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
  end

  always_comb begin
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc      = acc ^ stage_q[STAGES-1][i];
      bin_c[i] = acc;
    end
  end

  assign bin_o = bin_c;
endmodule

// File: rtl/fld_window.sv
// Free-running window counter in the reference domain.
module fld_window #(
  parameter int WIN_CYCLES = 16384,
  parameter int WIN_W      = 14
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIN_W-1:0] pos_o,
  output logic             win_end_o
);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)                pos_q <= '0;
    else if (pos_q == LAST) pos_q <= '0;
    else                    pos_q <= pos_q + 1'b1;
  end

  assign pos_o     = pos_q;
  assign win_end_o = (pos_q == LAST);
endmodule

// File: rtl/fld_lock_ctrl.sv
// Count compare with two thresholds and the lock state.
module fld_lock_ctrl
  import fld_pkg::*;
#(
  parameter int WIN_CYCLES = 16384,
  parameter int RATE_SHIFT = 2,
  parameter int LOSS_SHIFT = 10,
  parameter int ACQ_SHIFT  = 12,
  parameter int CNT_W      = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end_i,
  input  logic             rate_hi_i,
  input  logic             ovr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             locked_o,
  output logic             follow_o,
  output logic             primed_o
);
  logic [CNT_W-1:0] base_q, exp_cnt, delta, diff, mag, loss_tol, acq_tol;
  logic             in_acq, out_loss, primed_q, locked_q, follow_q;
  loop_sel_e        sel_q, sel_d;

  always_comb begin
    exp_cnt  = rate_hi_i ? (CNT_W'(WIN_CYCLES) << RATE_SHIFT) : CNT_W'(WIN_CYCLES);
    delta    = cnt_i - base_q;
    diff     = delta - exp_cnt;
    mag      = diff[CNT_W-1] ? (~diff + 1'b1) : diff;
    loss_tol = exp_cnt >> LOSS_SHIFT;
    acq_tol  = exp_cnt >> ACQ_SHIFT;
    in_acq   = (mag <= acq_tol);
    out_loss = (mag > loss_tol);
    sel_d    = sel_q;
    if (ovr_i) begin
      sel_d = LS_REF;
    end else if (win_end_i && primed_q) begin
      case (sel_q)
        LS_REF:  if (in_acq)   sel_d = LS_DATA;
        LS_DATA: if (out_loss) sel_d = LS_REF;
        default: sel_d = LS_REF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      primed_q <= 1'b0;
      sel_q    <= LS_REF;
      locked_q <= 1'b0;
      follow_q <= 1'b0;
    end else begin
      if (win_end_i) begin
        base_q   <= cnt_i;
        primed_q <= 1'b1;
      end
      sel_q    <= sel_d;
      locked_q <= (sel_d == LS_DATA);
      follow_q <= (sel_d == LS_DATA);
    end
  end

  assign locked_o = locked_q;
  assign follow_o = follow_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/fld_data_gate.sv
// Recovered-domain output gating driven by the synchronized override.
module fld_data_gate #(
  parameter int STAGES = 2
) (
  input  logic rec_clk,
  input  logic rec_rst,
  input  logic ovr_i,
  input  logic data_i,
  output logic ovr_rec_o,
  output logic data_o
);
  logic ovr_rec, data_q;

  fld_sync_bit #(.STAGES(STAGES)) u_ovr_sync (
    .clk (rec_clk),
    .d_i (ovr_i),
    .q_o (ovr_rec)
  );

  always_ff @(posedge rec_clk) begin
    if (rec_rst || ovr_rec) data_q <= 1'b0;
    else                    data_q <= data_i;
  end

  assign ovr_rec_o = ovr_rec;
  assign data_o    = data_q;
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
  import fld_pkg::*;
#(
  parameter int WIN_CYCLES = 16384,
  parameter int RATE_SHIFT = 2,
  parameter int DIV_LOG2   = 1,
  parameter int LOSS_SHIFT = 10,
  parameter int ACQ_SHIFT  = 12,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic rec_clk,
  input  logic rate_hi_i,
  input  logic sig_det_i,
  input  logic lock_ref_n_i,
  input  logic rx_data_i,
  output logic locked_o,
  output logic follow_data_o,
  output logic tx_data_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES);
  localparam int CNT_W = WIN_W + RATE_SHIFT + 2;

  logic             ovr, rec_rst, ovr_rec, win_end, primed;
  logic [WIN_W-1:0] win_pos;
  logic [CNT_W-1:0] rec_gray, ref_cnt;

  assign ovr = !sig_det_i || !lock_ref_n_i;

  fld_sync_bit #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (rec_clk),
    .d_i (rst),
    .q_o (rec_rst)
  );

  fld_rec_counter #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_rec_cnt (
    .rec_clk (rec_clk),
    .rec_rst (rec_rst),
    .gray_o  (rec_gray)
  );

  fld_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk    (ref_clk),
    .gray_i (rec_gray),
    .bin_o  (ref_cnt)
  );

  fld_window #(.WIN_CYCLES(WIN_CYCLES), .WIN_W(WIN_W)) u_win (
    .clk       (ref_clk),
    .rst       (rst),
    .pos_o     (win_pos),
    .win_end_o (win_end)
  );

  fld_lock_ctrl #(
    .WIN_CYCLES (WIN_CYCLES),
    .RATE_SHIFT (RATE_SHIFT),
    .LOSS_SHIFT (LOSS_SHIFT),
    .ACQ_SHIFT  (ACQ_SHIFT),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (ref_clk),
    .rst       (rst),
    .win_end_i (win_end),
    .rate_hi_i (rate_hi_i),
    .ovr_i     (ovr),
    .cnt_i     (ref_cnt),
    .locked_o  (locked_o),
    .follow_o  (follow_data_o),
    .primed_o  (primed)
  );

  fld_data_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .rec_clk   (rec_clk),
    .rec_rst   (rec_rst),
    .ovr_i     (ovr),
    .data_i    (rx_data_i),
    .ovr_rec_o (ovr_rec),
    .data_o    (tx_data_o)
  );
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
  parameter int WIN_CYCLES = 16384,
  parameter int WIN_W      = 14
) (
  input logic             ref_clk,
  input logic             rst,
  input logic             rec_clk,
  input logic             rec_rst,
  input logic             sig_det_i,
  input logic             lock_ref_n_i,
  input logic             win_end,
  input logic             primed,
  input logic [WIN_W-1:0] win_pos,
  input logic             ovr_rec,
  input logic             locked_o,
  input logic             follow_data_o,
  input logic             tx_data_o
);
  assert_reset_idle_R1: assert property (@(posedge ref_clk)
    rst |=> (!locked_o && !follow_data_o));

  assert_window_pos_R2: assert property (@(posedge ref_clk) disable iff (rst)
    32'(win_pos) < WIN_CYCLES);

  assert_rise_on_window_R3: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(locked_o) |-> ($past(win_end) && $past(primed)));

  assert_fall_cause_R5: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(locked_o) |-> ($past(win_end) || !$past(sig_det_i) || !$past(lock_ref_n_i)));

  assert_sd_drop_R6: assert property (@(posedge ref_clk) disable iff (rst)
    !sig_det_i |=> !locked_o);

  assert_lref_drop_R7: assert property (@(posedge ref_clk) disable iff (rst)
    !lock_ref_n_i |=> !locked_o);

  assert_gate_low_R8: assert property (@(posedge rec_clk) disable iff (rec_rst)
    ovr_rec |=> !tx_data_o);

  assert_follow_lock_R10: assert property (@(posedge ref_clk) disable iff (rst)
    follow_data_o == locked_o);
endmodule

bind freq_lock_det fld_checker #(.WIN_CYCLES(WIN_CYCLES), .WIN_W(WIN_W)) u_chk (
  .ref_clk       (ref_clk),
  .rst           (rst),
  .rec_clk       (rec_clk),
  .rec_rst       (rec_rst),
  .sig_det_i     (sig_det_i),
  .lock_ref_n_i  (lock_ref_n_i),
  .win_end       (win_end),
  .primed        (primed),
  .win_pos       (win_pos),
  .ovr_rec       (ovr_rec),
  .locked_o      (locked_o),
  .follow_data_o (follow_data_o),
  .tx_data_o     (tx_data_o)
);

// File: tb/sim_freq_lock_det.sv
module sim_freq_lock_det;
  localparam int REF_PERIOD = 80000;
  localparam int WIN        = 8192;
  localparam int WATCHDOG   = 190000;

  logic ref_clk = 1'b0, rst = 1'b1, rec_clk = 1'b0;
  logic rate_hi = 1'b1, sig_det = 1'b1, lock_ref_n = 1'b1, rx_data = 1'b0;
  logic locked, follow, tx_data;

  int    errors = 0, checks = 0;
  int    ppm = 0;
  int    k = 0;
  bit    m_lock = 1'b0;
  bit    done = 1'b0;
  string req = "R1";

  freq_lock_det #(.WIN_CYCLES(WIN)) u0 (
    .ref_clk       (ref_clk),
    .rst           (rst),
    .rec_clk       (rec_clk),
    .rate_hi_i     (rate_hi),
    .sig_det_i     (sig_det),
    .lock_ref_n_i  (lock_ref_n),
    .rx_data_i     (rx_data),
    .locked_o      (locked),
    .follow_data_o (follow),
    .tx_data_o     (tx_data)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  // Recovered clock: nominal divided rate is 1x (low) or 4x (high) the reference.
  initial begin
    #1234;
    forever begin
      int base, p;
      base = rate_hi ? REF_PERIOD/8 : REF_PERIOD/2;
      p = base - (base * ppm) / 1000000;
      rec_clk = 1'b1; #(p/2);
      rec_clk = 1'b0; #(p - p/2);
    end
  end

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Behavioural reference model of the lock decision.
  always @(posedge ref_clk) begin
    if (rst) begin
      k = 0;
      m_lock = 1'b0;
    end else begin
      k++;
      if (!sig_det || !lock_ref_n) m_lock = 1'b0;
      else if ((k % WIN) == 0 && (k / WIN) >= 2) begin
        if (m_lock) begin
          if (iabs(ppm) > 1000) m_lock = 1'b0;
        end else if (iabs(ppm) <= 250) m_lock = 1'b1;
      end
    end
  end

  always @(negedge ref_clk) begin
    if (!done) begin
      checks++;
      if (locked !== m_lock) begin
        errors++;
        $display("FAIL %s: locked_o=%0b expected %0b at cycle %0d", req, locked, m_lock, k);
      end
      checks++;
      if (follow !== m_lock) begin
        errors++;
        $display("FAIL R10: follow_data_o=%0b expected %0b at cycle %0d", follow, m_lock, k);
      end
    end
  end

  // Data path model in the recovered domain (R8).
  logic       cap = 1'b0, ovr_prev = 1'b0;
  int         stab = 0;
  logic [15:0] lf = 16'hACE1;
  always @(posedge rec_clk) begin
    cap <= rx_data;
    if ((!sig_det || !lock_ref_n) != ovr_prev) stab <= 0;
    else if (stab < 100) stab <= stab + 1;
    ovr_prev <= (!sig_det || !lock_ref_n);
  end

  always @(negedge rec_clk) begin
    logic e;
    if (!done && !rst && k > 4 && stab >= 4) begin
      e = ovr_prev ? 1'b0 : cap;
      checks++;
      if (tx_data !== e) begin
        errors++;
        $display("FAIL R8: tx_data_o=%0b expected %0b at cycle %0d", tx_data, e, k);
      end
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rx_data <= lf[0];
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic expect_lock(bit e, string r);
    checks++;
    if (locked !== e) begin
      errors++;
      $display("FAIL %s: locked_o=%0b expected %0b", r, locked, e);
    end
  endtask

  task automatic wait_windows(int n);
    int target;
    target = ((k / WIN) + n) * WIN;
    while (k < target) @(negedge ref_clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge ref_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run still active=1 expected 0");
      finish_run();
    end
  end

  initial begin
    repeat (10) @(negedge ref_clk);
    // R1: reset state
    checks++;
    if (locked !== 1'b0 || follow !== 1'b0 || tx_data !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs=%0b%0b%0b expected 000", locked, follow, tx_data);
    end
    rst = 1'b0;

    // R2: first window end only records a baseline
    req = "R2"; wait_windows(1); expect_lock(1'b0, "R2");
    req = "R3"; wait_windows(1); expect_lock(1'b1, "R3");   // 0 ppm, high rate (R9)
    req = "R4"; ppm = 600;   wait_windows(1); expect_lock(1'b1, "R4");
    req = "R5"; ppm = 1500;  wait_windows(1); expect_lock(1'b0, "R5");
    req = "R4"; ppm = 600;   wait_windows(1); expect_lock(1'b0, "R4");
    req = "R3"; ppm = 200;   wait_windows(1); expect_lock(1'b1, "R3");
    req = "R4"; ppm = -600;  wait_windows(1); expect_lock(1'b1, "R4");
    req = "R5"; ppm = -1500; wait_windows(1); expect_lock(1'b0, "R5");
    req = "R3"; ppm = -200;  wait_windows(1); expect_lock(1'b1, "R3");

    // R6: signal detect loss mid-window
    ppm = 0;
    repeat (100) @(negedge ref_clk);
    req = "R6"; sig_det = 1'b0;
    @(negedge ref_clk); expect_lock(1'b0, "R6");
    wait_windows(1); expect_lock(1'b0, "R6");
    sig_det = 1'b1; req = "R3";
    wait_windows(1); expect_lock(1'b1, "R3");

    // R7: forced reference, with the rate switched underneath (R9)
    repeat (100) @(negedge ref_clk);
    req = "R7"; lock_ref_n = 1'b0;
    @(negedge ref_clk); expect_lock(1'b0, "R7");
    rate_hi = 1'b0;
    wait_windows(1); expect_lock(1'b0, "R7");
    lock_ref_n = 1'b1; req = "R9";
    wait_windows(1); expect_lock(1'b1, "R9");
    ppm = 600;  wait_windows(1); expect_lock(1'b1, "R9");
    ppm = 1500; wait_windows(1); expect_lock(1'b0, "R9");
    ppm = 0;    wait_windows(1); expect_lock(1'b1, "R9");

    repeat (20) @(negedge ref_clk);
    finish_run();
  end
endmodule